// File: doc/BRIEF.md
# Hardwired Instruction Cycle Sequencer

This block is the timing and control core of a small 16-bit accumulator machine. A 4-bit step counter is decoded into a one-hot set of timing states. A 3-bit operation field is decoded into one-hot operation lines. Together with the direct/indirect flag, these produce every control strobe the machine needs for one instruction. Those strobes are register loads, increments and clears, memory read and write, and the 3-bit select of a shared 16-bit transfer bus.

The block holds the address, program counter, instruction and data registers. It also holds the bus multiplexer that joins them. Memory sits outside the block and answers a read within the same timing state. The accumulator also sits outside the block: its value comes in for stores, and the block tells it, through strobes, when to combine with, add or take the operand.

Instructions vary in length. Every instruction passes through fetch and decode. Memory-reference instructions may spend one more step on an indirect pointer read, then run their own execution steps. The counter returns to the first state when an instruction completes. Register-type and input/output instructions are handed out as strobes in the fourth state, with the low twelve instruction bits exposed, and they finish there.

Top module: `acs_seq_ctrl`

## Requirements
- R1: `timing` is one-hot, bit k set while the step counter equals k. The counter advances by one per clock unless it is cleared or held. It never reaches state 7 or above.
- R2: In state 0, the bus carries the program counter (`bus_sel`=2) and the address register loads it. In state 1, memory is read (`mem_rd`=1, `bus_sel`=7) into the instruction register, and the program counter increments.
- R3: In state 2, the bus carries the instruction register (`bus_sel`=5), and the address register takes instruction bits 11..0. On that edge, instruction bits 14..12 become the one-hot `dec` and bit 15 becomes `ind`. After reset, `dec`=8'h01.
- R4: When `dec[7]`=1 in state 3, `rr_exec` pulses if `ind`=0 and `io_exec` pulses if `ind`=1, with `op_bits` = instruction bits 11..0. The next state is 0.
- R5: When `dec[7]`=0 in state 3, `ind`=1 reads memory at the address register into the address register (`mem_rd`=1, `bus_sel`=7). `ind`=0 gives no read, no write and `bus_sel`=0.
- R6: Opcodes 0, 1 and 2 read memory into the data register in state 4. In state 5 they drive `bus_sel`=3, pulse `ac_and`, `ac_add` or `ac_load` respectively with `dr_out` as operand, and return to state 0.
- R7: Opcode 3 writes `ac_in` to memory at the address register in state 4 (`mem_wr`=1, `bus_sel`=4) and returns to state 0.
- R8: Opcode 4 loads the program counter from the address register in state 4 (`bus_sel`=1) and returns to state 0.
- R9: Opcode 5 writes the zero-extended program counter to memory at the address register and increments the address register in state 4 (`bus_sel`=2). In state 5 it loads the program counter from the address register (`bus_sel`=1) and returns to state 0.
- R10: Opcode 6 reads the data register in state 4 and increments it in state 5. In state 6 it writes the data register back (`mem_wr`=1, `bus_sel`=3), increments the program counter if the data register is zero, and returns to state 0.
- R11: Bus codes are 1 address, 2 program counter, 3 data, 4 accumulator, 5 instruction, 7 memory, 0 idle. `mem_wdata` equals the bus value. `mem_rd` and `mem_wr` are never both high.
- R12: While `halt`=1, the counter holds. There is no memory access and no strobe, `bus_sel`=0, and no register changes.
- R13: Synchronous reset returns to state 0 with the program counter, address, instruction and data registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze the sequencer |
| mem_rdata | input | 16 | Memory read data at `mem_addr` |
| ac_in | input | 16 | External accumulator value |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (bus value) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_sel | output | 3 | Bus source code |
| timing | output | 16 | One-hot timing state |
| dec | output | 8 | One-hot decoded opcode |
| ind | output | 1 | Indirect flag |
| pc_out | output | 12 | Program counter |
| dr_out | output | 16 | Data register (operand) |
| op_bits | output | 12 | Instruction bits 11..0 |
| rr_exec | output | 1 | Register-type instruction strobe |
| io_exec | output | 1 | Input/output instruction strobe |
| ac_and | output | 1 | Accumulator AND strobe |
| ac_add | output | 1 | Accumulator add strobe |
| ac_load | output | 1 | Accumulator load strobe |

## Verification
A wrong step count or a missed counter clear shows within one clock as a wrong `timing` bit and a wrong `bus_sel` or memory strobe. A wrong address, program counter or data register shows on `mem_addr`, `pc_out` or `dr_out` on the next clock. A corrupted write shows in the written memory word, which a later fetch or load turns into a visibly different instruction stream. A wrong decode or indirect flag sends the instruction down the wrong length of execution steps, so the program counter path diverges within one instruction.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int BUS_SEL_W = 3;
  localparam int NUM_SRC   = 1 << BUS_SEL_W;

  localparam int SRC_AR  = 1;
  localparam int SRC_PC  = 2;
  localparam int SRC_DR  = 3;
  localparam int SRC_AC  = 4;
  localparam int SRC_IR  = 5;
  localparam int SRC_TR  = 6;
  localparam int SRC_MEM = 7;

  typedef struct packed {
    logic ar_ld;
    logic ar_inr;
    logic pc_ld;
    logic pc_inr;
    logic ir_ld;
    logic dr_ld;
    logic dr_inr;
    logic dec_ld;
    logic mem_rd;
    logic mem_wr;
    logic sc_clr;
    logic rr_exec;
    logic io_exec;
    logic ac_and;
    logic ac_add;
    logic ac_load;
    logic [NUM_SRC-1:0] bus_req;
  } ctrl_t;
endpackage

// File: rtl/acs_seq_counter.sv
module acs_seq_counter #(
  parameter int SC_W = 4,
  localparam int NT = 1 << SC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          clr,
  output logic [NT-1:0] t_onehot
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst)       sc_q <= '0;
    else if (hold) sc_q <= sc_q;
    else if (clr)  sc_q <= '0;
    else           sc_q <= sc_q + 1'b1;
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_tdec
    assign t_onehot[gi] = (sc_q == SC_W'(gi));
  end
endmodule

// File: rtl/acs_op_decoder.sv
module acs_op_decoder #(
  parameter int OP_W = 3,
  localparam int ND = 1 << OP_W
) (
  input  logic [OP_W-1:0] op,
  output logic [ND-1:0]   d
);
  for (genvar gi = 0; gi < ND; gi++) begin : g_ddec
    assign d[gi] = (op == OP_W'(gi));
  end
endmodule

// File: rtl/acs_bus_encoder.sv
module acs_bus_encoder #(
  parameter int SEL_W = 3,
  localparam int NS = 1 << SEL_W
) (
  input  logic [NS-1:0]    req,
  output logic [SEL_W-1:0] sel
);
  for (genvar gb = 0; gb < SEL_W; gb++) begin : g_bit
    logic [NS-1:0] mask;
    always_comb begin
      for (int k = 0; k < NS; k++) mask[k] = ((k >> gb) & 1) == 1;
    end
    assign sel[gb] = |(req & mask);
  end
endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int NT = 16,
  parameter int ND = 8
) (
  input  logic          en,
  input  logic [NT-1:0] t,
  input  logic [ND-1:0] d,
  input  logic          ind,
  input  logic          dr_zero,
  output ctrl_t         c
);
  logic mem_operand;
  assign mem_operand = d[0] | d[1] | d[2] | d[6];

  always_comb begin
    c = '0;
    if (en) begin
      if (t[0]) begin
        c.bus_req[SRC_PC] = 1'b1;
        c.ar_ld = 1'b1;
      end
      if (t[1]) begin
        c.mem_rd = 1'b1;
        c.bus_req[SRC_MEM] = 1'b1;
        c.ir_ld = 1'b1;
        c.pc_inr = 1'b1;
      end
      if (t[2]) begin
        c.bus_req[SRC_IR] = 1'b1;
        c.ar_ld = 1'b1;
        c.dec_ld = 1'b1;
      end
      if (t[3]) begin
        if (d[7]) begin
          c.rr_exec = !ind;
          c.io_exec = ind;
          c.sc_clr = 1'b1;
        end else if (ind) begin
          c.mem_rd = 1'b1;
          c.bus_req[SRC_MEM] = 1'b1;
          c.ar_ld = 1'b1;
        end
      end
      if (t[4]) begin
        if (mem_operand) begin
          c.mem_rd = 1'b1;
          c.bus_req[SRC_MEM] = 1'b1;
          c.dr_ld = 1'b1;
        end
        if (d[3]) begin
          c.mem_wr = 1'b1;
          c.bus_req[SRC_AC] = 1'b1;
          c.sc_clr = 1'b1;
        end
        if (d[4]) begin
          c.bus_req[SRC_AR] = 1'b1;
          c.pc_ld = 1'b1;
          c.sc_clr = 1'b1;
        end
        if (d[5]) begin
          c.mem_wr = 1'b1;
          c.bus_req[SRC_PC] = 1'b1;
          c.ar_inr = 1'b1;
        end
      end
      if (t[5]) begin
        if (d[0] | d[1] | d[2]) begin
          c.bus_req[SRC_DR] = 1'b1;
          c.ac_and  = d[0];
          c.ac_add  = d[1];
          c.ac_load = d[2];
          c.sc_clr  = 1'b1;
        end
        if (d[5]) begin
          c.bus_req[SRC_AR] = 1'b1;
          c.pc_ld = 1'b1;
          c.sc_clr = 1'b1;
        end
        if (d[6]) c.dr_inr = 1'b1;
      end
      if (t[6] && d[6]) begin
        c.bus_req[SRC_DR] = 1'b1;
        c.mem_wr = 1'b1;
        c.pc_inr = dr_zero;
        c.sc_clr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/acs_seq_ctrl.sv
module acs_seq_ctrl
  import acs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4,
  parameter int OP_W   = 3,
  localparam int NT    = 1 << SC_W,
  localparam int ND    = 1 << OP_W,
  localparam int IND_BIT = DATA_W - 1,
  localparam int OP_LSB  = IND_BIT - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] ac_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BUS_SEL_W-1:0] bus_sel,
  output logic [NT-1:0]     timing,
  output logic [ND-1:0]     dec,
  output logic              ind,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] dr_out,
  output logic [ADDR_W-1:0] op_bits,
  output logic              rr_exec,
  output logic              io_exec,
  output logic              ac_and,
  output logic              ac_add,
  output logic              ac_load
);
  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [DATA_W-1:0] ir_q, dr_q, bus;
  logic [OP_W-1:0]   op_q;
  logic              ind_q;
  ctrl_t             c;

  acs_seq_counter #(.SC_W(SC_W)) i_sc (
    .clk(clk), .rst(rst), .hold(halt), .clr(c.sc_clr), .t_onehot(timing)
  );

  acs_op_decoder #(.OP_W(OP_W)) i_dec (.op(op_q), .d(dec));

  acs_ctrl #(.NT(NT), .ND(ND)) i_ctrl (
    .en(!halt), .t(timing), .d(dec), .ind(ind_q),
    .dr_zero(dr_q == '0), .c(c)
  );

  acs_bus_encoder #(.SEL_W(BUS_SEL_W)) i_enc (.req(c.bus_req), .sel(bus_sel));

  always_comb begin
    case (int'(bus_sel))
      SRC_AR:  bus = DATA_W'(ar_q);
      SRC_PC:  bus = DATA_W'(pc_q);
      SRC_DR:  bus = dr_q;
      SRC_AC:  bus = ac_in;
      SRC_IR:  bus = ir_q;
      SRC_MEM: bus = mem_rdata;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q  <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      op_q  <= '0;
      ind_q <= 1'b0;
    end else begin
      if (c.ar_ld)       ar_q <= bus[ADDR_W-1:0];
      else if (c.ar_inr) ar_q <= ar_q + 1'b1;
      if (c.pc_ld)       pc_q <= bus[ADDR_W-1:0];
      else if (c.pc_inr) pc_q <= pc_q + 1'b1;
      if (c.ir_ld)       ir_q <= bus;
      if (c.dr_ld)       dr_q <= bus;
      else if (c.dr_inr) dr_q <= dr_q + 1'b1;
      if (c.dec_ld) begin
        op_q  <= ir_q[OP_LSB +: OP_W];
        ind_q <= ir_q[IND_BIT];
      end
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = bus;
  assign mem_rd    = c.mem_rd;
  assign mem_wr    = c.mem_wr;
  assign ind       = ind_q;
  assign pc_out    = pc_q;
  assign dr_out    = dr_q;
  assign op_bits   = ir_q[ADDR_W-1:0];
  assign rr_exec   = c.rr_exec;
  assign io_exec   = c.io_exec;
  assign ac_and    = c.ac_and;
  assign ac_add    = c.ac_add;
  assign ac_load   = c.ac_load;
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int NT = 16,
  parameter int ND = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic [NT-1:0]     timing,
  input logic [ND-1:0]     dec,
  input logic              ind,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [2:0]        bus_sel,
  input logic [ADDR_W-1:0] pc_out
);
  AST_TIMING_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(timing) == 1); // R1
  AST_NO_LATE_STATE: assert property (@(posedge clk) disable iff (rst) timing[NT-1:7] == '0); // R1
  AST_FETCH_READ: assert property (@(posedge clk) disable iff (rst) (timing[1] && !halt) |-> (mem_rd && bus_sel == 3'd7)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (timing[1] && !halt) |=> (pc_out == $past(pc_out) + 1'b1)); // R2
  AST_REGIO_RETURN: assert property (@(posedge clk) disable iff (rst) (timing[3] && dec[7] && !halt) |=> timing[0]); // R4
  AST_DIRECT_IDLE: assert property (@(posedge clk) disable iff (rst) (timing[3] && !dec[7] && !ind && !halt) |-> (!mem_rd && !mem_wr && bus_sel == 3'd0)); // R5
  AST_ISZ_RETURN: assert property (@(posedge clk) disable iff (rst) (timing[6] && dec[6] && !halt) |=> timing[0]); // R10
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst) halt |-> (!mem_rd && !mem_wr && bus_sel == 3'd0)); // R12
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst) halt |=> $stable(timing)); // R12
endmodule

bind acs_seq_ctrl acs_checker #(.NT(NT), .ND(ND), .ADDR_W(ADDR_W)) i_acs_checker (
  .clk(clk), .rst(rst), .halt(halt), .timing(timing), .dec(dec), .ind(ind),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_sel(bus_sel), .pc_out(pc_out)
);

// File: tb/test_acs_seq_ctrl.sv
module test_acs_seq_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, halt;
  logic [15:0] mem_rdata, ac_in, mem_wdata, dr_out;
  logic [11:0] mem_addr, pc_out, op_bits;
  logic        mem_rd, mem_wr, ind, rr_exec, io_exec, ac_and, ac_add, ac_load;
  logic [2:0]  bus_sel;
  logic [15:0] timing;
  logic [7:0]  dec;

  acs_seq_ctrl i_acs_seq_ctrl (
    .clk(clk), .rst(rst), .halt(halt), .mem_rdata(mem_rdata), .ac_in(ac_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_sel(bus_sel), .timing(timing), .dec(dec), .ind(ind), .pc_out(pc_out),
    .dr_out(dr_out), .op_bits(op_bits), .rr_exec(rr_exec), .io_exec(io_exec),
    .ac_and(ac_and), .ac_add(ac_add), .ac_load(ac_load)
  );

  logic [15:0] mem [0:4095];
  logic [15:0] ac;
  assign mem_rdata = mem[mem_addr];
  assign ac_in = ac;

  int n_tests = 0, n_fail = 0;
  bit started = 0;
  int m_t;
  logic [2:0]  m_op;
  logic        m_ind;
  logic [11:0] m_pc, m_ar;
  logic [15:0] m_ir, m_dr;
  logic        c_wr = 0, c_and = 0, c_add = 0, c_load = 0;
  logic [11:0] c_addr = '0;
  logic [15:0] c_wdata = '0, c_dr = '0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : cmp
    string tag;
    logic e_rd, e_wr, mop;
    logic [2:0] e_sel;
    logic [2:0] e_acs;
    logic [15:0] e_wd;
    if (started) begin
      mop = (m_op <= 3'd2) || (m_op == 3'd6);
      e_rd = 0; e_wr = 0; e_sel = 0; e_acs = 0; e_wd = 16'h0;
      case (m_t)
        0: e_sel = 3'd2;
        1: begin e_rd = 1; e_sel = 3'd7; end
        2: e_sel = 3'd5;
        3: if (m_op != 3'd7 && m_ind) begin e_rd = 1; e_sel = 3'd7; end
        4: begin
          if (mop) begin e_rd = 1; e_sel = 3'd7; end
          if (m_op == 3'd3) begin e_wr = 1; e_sel = 3'd4; e_wd = ac; end
          if (m_op == 3'd4) e_sel = 3'd1;
          if (m_op == 3'd5) begin e_wr = 1; e_sel = 3'd2; e_wd = {4'h0, m_pc}; end
        end
        5: begin
          if (m_op <= 3'd2) begin e_sel = 3'd3; e_acs = 3'b100 >> m_op; end
          if (m_op == 3'd5) e_sel = 3'd1;
        end
        6: if (m_op == 3'd6) begin e_wr = 1; e_sel = 3'd3; e_wd = m_dr; end
        default: ;
      endcase
      if (halt) begin e_rd = 0; e_wr = 0; e_sel = 0; e_acs = 0; end
      if (rst) tag = "R13";
      else if (halt) tag = "R12";
      else if (m_t <= 1) tag = "R2";
      else if (m_t == 2) tag = "R3";
      else if (m_t == 3) tag = (m_op == 3'd7) ? "R4" : "R5";
      else case (m_op)
        3'd3: tag = "R7";
        3'd4: tag = "R8";
        3'd5: tag = "R9";
        3'd6: tag = "R10";
        default: tag = "R6";
      endcase
      check("R1", "timing", 32'(timing), 32'(16'h1 << m_t));
      check("R11", "bus_sel", 32'(bus_sel), 32'(e_sel));
      check(tag, "mem_rd", 32'(mem_rd), 32'(e_rd));
      check(tag, "mem_wr", 32'(mem_wr), 32'(e_wr));
      if (e_wr) check(tag, "mem_wdata", 32'(mem_wdata), 32'(e_wd));
      check(tag, "mem_addr", 32'(mem_addr), 32'(m_ar));
      check(tag, "pc_out", 32'(pc_out), 32'(m_pc));
      check(tag, "dr_out", 32'(dr_out), 32'(m_dr));
      check("R3", "dec", 32'(dec), 32'(8'h1 << m_op));
      check("R3", "ind", 32'(ind), 32'(m_ind));
      check("R6", "ac strobes", 32'({ac_and, ac_add, ac_load}), 32'(e_acs));
      check("R4", "rr/io strobes", 32'({rr_exec, io_exec}),
            32'((!halt && m_t == 3 && m_op == 3'd7) ? (m_ind ? 2'b01 : 2'b10) : 2'b00));
      if (!halt && m_t == 3 && m_op == 3'd7) check("R4", "op_bits", 32'(op_bits), 32'(m_ir[11:0]));
      c_wr = mem_wr; c_addr = mem_addr; c_wdata = mem_wdata;
      c_and = ac_and; c_add = ac_add; c_load = ac_load; c_dr = dr_out;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_t = 0; m_pc = '0; m_ar = '0; m_ir = '0; m_dr = '0; m_op = '0; m_ind = 0;
    end else if (!halt) begin
      case (m_t)
        0: begin m_ar = m_pc; m_t = 1; end
        1: begin m_ir = mem[m_ar]; m_pc = m_pc + 1; m_t = 2; end
        2: begin m_op = m_ir[14:12]; m_ind = m_ir[15]; m_ar = m_ir[11:0]; m_t = 3; end
        3: if (m_op == 3'd7) m_t = 0;
           else begin if (m_ind) m_ar = mem[m_ar][11:0]; m_t = 4; end
        4: case (m_op)
             3'd3, 3'd4: begin if (m_op == 3'd4) m_pc = m_ar; m_t = 0; end
             3'd5: begin m_ar = m_ar + 1; m_t = 5; end
             default: begin m_dr = mem[m_ar]; m_t = 5; end
           endcase
        5: begin
          if (m_op == 3'd5) m_pc = m_ar;
          if (m_op == 3'd6) begin m_dr = m_dr + 1; m_t = 6; end
          else m_t = 0;
        end
        default: begin if (m_dr == 16'h0) m_pc = m_pc + 1; m_t = 0; end
      endcase
    end
    if (c_wr) mem[c_addr] = c_wdata;
    if (c_and) ac = ac & c_dr;
    if (c_add) ac = ac + c_dr;
    if (c_load) ac = c_dr;
    started = 1;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    ac = 16'h0;
    mem[12'h000] = 16'h2100; // load
    mem[12'h001] = 16'h1101; // add
    mem[12'h002] = 16'h8102; // and, indirect
    mem[12'h003] = 16'h3104; // store
    mem[12'h004] = 16'h6105; // inc-skip, wraps to zero
    mem[12'h005] = 16'h7800; // skipped
    mem[12'h006] = 16'h6106; // inc-skip, no skip
    mem[12'h007] = 16'h5110; // call
    mem[12'h008] = 16'h4020; // jump
    mem[12'h020] = 16'h4020; // loop
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'h1111;
    mem[12'h102] = 16'h0103;
    mem[12'h103] = 16'h0FF0;
    mem[12'h105] = 16'hFFFF;
    mem[12'h106] = 16'h0005;
    mem[12'h111] = 16'h7020; // register-type
    mem[12'h112] = 16'hF080; // input/output
    mem[12'h113] = 16'hC110; // return, indirect jump
    rst = 1; halt = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    repeat (30) @(posedge clk);
    #1 halt = 1;
    repeat (6) @(posedge clk);
    #1 halt = 0;
    repeat (150) @(posedge clk);
    @(negedge clk);
    check("R6", "accumulator result", 32'(ac), 32'h0340);
    check("R7", "stored word", 32'(mem[12'h104]), 32'h0340);
    check("R10", "wrapped counter word", 32'(mem[12'h105]), 32'h0000);
    check("R10", "incremented word", 32'(mem[12'h106]), 32'h0006);
    check("R9", "saved return address", 32'(mem[12'h110]), 32'h0008);
    #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    summary();
  end
endmodule